// File: doc/BRIEF.md
# Three-Channel Interval Timer

The block holds three independent 16-bit down-counters that share one byte-wide register port. A control byte written to address 3 picks a channel, sets how its 16-bit values move across the 8-bit bus, and picks its counting behaviour. A control byte can also freeze a snapshot of a channel's count for a later read. Addresses 0, 1 and 2 carry the reload value in and the count (or the frozen snapshot) out, one byte per access.

Every channel advances on the shared `tick` input, which is a clock enable. Three counting behaviours are supported: a one-shot that fires once at terminal count, a rate generator that fires and reloads every N ticks, and a square-wave generator that steps by two and fires on every second expiry. The events of channel 0 leave the block as a one-cycle interrupt request on `irq0`. The events of channels 1 and 2 do not leave the block.

Top module: `interval_timer3`

## Requirements
- R1: A write to address 3 is a control byte. Bits 7:6 select the channel (0 to 2), bits 5:4 select the access mode, and bits 3:1 select the operating mode. A control byte with channel field 3 changes no state.
- R2: A control byte with access field 0 copies the channel's current count into its snapshot register and marks the snapshot valid. It changes nothing else.
- R3: Any other control byte stores the access mode and the operating mode. It clears the fired-once flag, the snapshot-valid flag, the byte-order flip-flop and the square-wave output. Mode codes 6 and 7 act as modes 2 and 3.
- R4: A data write or read at address 0 to 2 uses the selected channel's access mode. Access 1 moves the low byte only, access 2 moves the high byte only, and access 3 moves the low byte and then the high byte, toggling the flip-flop on each access. The count is loaded from the reload value when a write completes a value: after the single byte in access 1 or 2, and after the high byte in access 3.
- R5: While the snapshot is valid, a read returns the snapshot instead of the live count. The snapshot is released after one read in access 1 or 2, and after the high-byte read in access 3.
- R6: Mode 0 decrements the count on each tick. The channel fires only on the first arrival at zero. After that the count keeps wrapping, but the channel stays silent until the next mode-setting control byte.
- R7: Mode 2 decrements the count on each tick. On reaching zero the channel fires and reloads, so it fires every N ticks for a reload value N.
- R8: Mode 3 subtracts 2 on each tick. On reaching zero it toggles its output, fires only when the output goes from low to high, and reloads the reload value with bit 0 cleared.
- R9: In modes 1, 4 and 5 the count does not change on ticks.
- R10: `irq0` pulses high for exactly one cycle, in the cycle after a tick on which channel 0 fires. Channels 1 and 2 never drive it. Without `tick`, no count changes.
- R11: After reset every channel has access mode 0 and holds its count (it behaves as mode 1). In this state, data reads return 0 and `irq0` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counting enable for all channels |
| wr_en | input | 1 | Write strobe for the byte at `addr` |
| rd_en | input | 1 | Read strobe; advances read sequencing |
| addr | input | 2 | 0 to 2 selects channel data, 3 selects control |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte for `addr`, valid in the same cycle as `rd_en` |
| irq0 | output | 1 | One-cycle event pulse from channel 0 |

## Verification
`rdata` is combinational. The bench therefore samples it in the same cycle that it raises `rd_en`, before the edge at which the byte-order flip-flop and the snapshot release take effect. A tick applied before an edge shows up in the count at that edge, and any `irq0` pulse appears in the following cycle. The bench samples both half a period after that edge. It then checks that `irq0` is low again one cycle later. Expected counts and interrupt positions come from closed-form arithmetic on the reload value and the tick index, swept over several reload values for each counting mode.

// File: rtl/interval_timer3.sv
module interval_timer3 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq0
);
  localparam int NCH = 3;

  logic [15:0] reload_q [NCH];
  logic [15:0] count_q  [NCH];
  logic [15:0] snap_q   [NCH];
  logic [1:0]  acc_q    [NCH];
  logic [2:0]  mode_q   [NCH];
  logic        fired_q  [NCH];
  logic        snapv_q  [NCH];
  logic        ff_q     [NCH];
  logic        out_q    [NCH];

  logic [15:0] nxt_cnt  [NCH];
  logic        fire     [NCH];
  logic        tog      [NCH];

  wire ctl_wr = wr_en && addr == 2'd3;
  wire [2:0] ctl_mode = (wdata[3:2] == 2'b11) ? {1'b0, wdata[2:1]} : wdata[3:1];

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      nxt_cnt[i] = count_q[i];
      fire[i] = 1'b0;
      tog[i] = 1'b0;
      case (mode_q[i])
        3'd0: begin
          nxt_cnt[i] = count_q[i] - 16'd1;
          fire[i] = (nxt_cnt[i] == 16'd0) && !fired_q[i];
        end
        3'd2: begin
          nxt_cnt[i] = count_q[i] - 16'd1;
          if (nxt_cnt[i] == 16'd0) begin
            fire[i] = 1'b1;
            nxt_cnt[i] = reload_q[i];
          end
        end
        3'd3: begin
          nxt_cnt[i] = count_q[i] - 16'd2;
          if (nxt_cnt[i] == 16'd0) begin
            tog[i] = 1'b1;
            fire[i] = !out_q[i];
            nxt_cnt[i] = {reload_q[i][15:1], 1'b0};
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    logic [15:0] v;
    rdata = 8'h00;
    v = 16'h0000;
    if (addr != 2'd3) begin
      v = snapv_q[addr] ? snap_q[addr] : count_q[addr];
      case (acc_q[addr])
        2'd1: rdata = v[7:0];
        2'd2: rdata = v[15:8];
        2'd3: rdata = ff_q[addr] ? v[15:8] : v[7:0];
        default: rdata = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq0 <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        reload_q[i] <= '0;
        count_q[i]  <= '0;
        snap_q[i]   <= '0;
        acc_q[i]    <= 2'd0;
        mode_q[i]   <= 3'd1;
        fired_q[i]  <= 1'b0;
        snapv_q[i]  <= 1'b0;
        ff_q[i]     <= 1'b0;
        out_q[i]    <= 1'b0;
      end
    end else begin
      irq0 <= tick && fire[0];
      for (int i = 0; i < NCH; i++) begin
        if (tick) begin
          count_q[i] <= nxt_cnt[i];
          if (fire[i] && mode_q[i] == 3'd0) fired_q[i] <= 1'b1;
          if (tog[i]) out_q[i] <= !out_q[i];
        end
        if (ctl_wr && wdata[7:6] == 2'(i)) begin
          if (wdata[5:4] == 2'd0) begin
            snap_q[i]  <= count_q[i];
            snapv_q[i] <= 1'b1;
          end else begin
            acc_q[i]   <= wdata[5:4];
            mode_q[i]  <= ctl_mode;
            fired_q[i] <= 1'b0;
            snapv_q[i] <= 1'b0;
            ff_q[i]    <= 1'b0;
            out_q[i]   <= 1'b0;
          end
        end
        if (wr_en && addr == 2'(i)) begin
          case (acc_q[i])
            2'd1: begin
              reload_q[i][7:0] <= wdata;
              count_q[i] <= {reload_q[i][15:8], wdata};
            end
            2'd2: begin
              reload_q[i][15:8] <= wdata;
              count_q[i] <= {wdata, reload_q[i][7:0]};
            end
            2'd3: begin
              ff_q[i] <= !ff_q[i];
              if (!ff_q[i]) reload_q[i][7:0] <= wdata;
              else begin
                reload_q[i][15:8] <= wdata;
                count_q[i] <= {wdata, reload_q[i][7:0]};
              end
            end
            default: ;
          endcase
        end
        if (rd_en && addr == 2'(i)) begin
          case (acc_q[i])
            2'd1, 2'd2: snapv_q[i] <= 1'b0;
            2'd3: begin
              ff_q[i] <= !ff_q[i];
              if (ff_q[i]) snapv_q[i] <= 1'b0;
            end
            default: ;
          endcase
        end
      end
    end
  end

  p_irq_after_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq0 |-> $past(tick));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    p_no_tick_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !(wr_en && addr == 2'(g))) |=> count_q[g] == $past(count_q[g]));
    p_idle_modes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q[g] == 3'd1 || mode_q[g] == 3'd4 || mode_q[g] == 3'd5) && !(wr_en && addr == 2'(g)))
      |=> count_q[g] == $past(count_q[g]));
    p_snapshot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && wdata[7:6] == 2'(g) && wdata[5:4] == 2'd0)
      |=> snapv_q[g] && snap_q[g] == $past(count_q[g]));
    p_mode_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q[g] <= 3'd5);
  end
endmodule

// File: tb/interval_timer3_tb.sv
module interval_timer3_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic irq0;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  interval_timer3 u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq0(irq0));

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rd16(input logic [1:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a, hi); v = {hi, lo};
  endtask

  task automatic do_tick(output logic irq);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; irq = irq0;
  endtask

  initial begin
    logic [7:0] b;
    logic [15:0] v;
    logic irq;
    int pulses;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    check(irq0 == 1'b0, "R11 irq0 low", irq0, 0);
    for (int c = 0; c < 3; c++) begin
      rd(2'(c), b); check(b == 8'h00, "R11 read in access 0", b, 0);
    end
    for (int k = 0; k < 4; k++) begin
      do_tick(irq); check(irq == 1'b0, "R11 idle no irq", irq, 0);
    end
    // R4 access 3 load and read back
    wr(3, 8'h34); wr(0, 8'hCD); wr(0, 8'hAB);
    rd16(0, v); check(v == 16'hABCD, "R4 access 3 load", v, 16'hABCD);
    // R1 channel field 3 ignored
    wr(3, 8'hC0); wr(3, 8'hF6);
    rd16(0, v); check(v == 16'hABCD, "R1 channel 3 ignored", v, 16'hABCD);
    rd16(0, v); check(v == 16'hABCD, "R1 no snapshot side effect", v, 16'hABCD);
    // R7 mode 2 sweep
    for (int r = 2; r <= 6; r++) begin
      wr(3, 8'h34); wr(0, 8'(r)); wr(0, 8'h00);
      for (int k = 1; k <= 3 * r; k++) begin
        do_tick(irq);
        check(irq == (k % r == 0), "R7 mode 2 irq", irq, (k % r == 0));
        if (irq) begin
          @(negedge clk); check(irq0 == 1'b0, "R10 one-cycle pulse", irq0, 0);
        end
        rd16(0, v);
        check(v == 16'((k % r == 0) ? r : r - k % r), "R7 mode 2 count", v, (k % r == 0) ? r : r - k % r);
      end
    end
    // R3 alias 6 -> 2
    wr(3, 8'h3C); wr(0, 8'h03); wr(0, 8'h00);
    pulses = 0;
    for (int k = 1; k <= 9; k++) begin
      do_tick(irq); if (irq) pulses++;
      check(irq == (k % 3 == 0), "R3 mode 6 acts as 2", irq, (k % 3 == 0));
    end
    // R6 mode 0 sweep
    for (int r = 1; r <= 4; r++) begin
      wr(3, 8'h30); wr(0, 8'(r)); wr(0, 8'h00);
      for (int k = 1; k <= r + 3; k++) begin
        do_tick(irq);
        check(irq == (k == r), "R6 mode 0 single fire", irq, (k == r));
        rd16(0, v);
        check(v == 16'(r - k), "R6 mode 0 count", v, 16'(r - k));
      end
    end
    // R8 mode 3 sweep (even reloads)
    for (int r = 4; r <= 10; r += 2) begin
      wr(3, 8'h36); wr(0, 8'(r)); wr(0, 8'h00);
      for (int k = 1; k <= 2 * r; k++) begin
        int st, m, ex;
        st = r / 2; m = k % st;
        ex = (m == 0 && ((k / st) % 2 == 1)) ? 1 : 0;
        do_tick(irq);
        check(irq == ex[0], "R8 mode 3 irq on rising output", irq, ex);
        rd16(0, v);
        check(v == 16'((m == 0) ? r : r - 2 * m), "R8 mode 3 count", v, (m == 0) ? r : r - 2 * m);
      end
    end
    // R8 odd reload rounded down; R3 control clears flip-flop
    wr(3, 8'h36); wr(0, 8'h08); wr(0, 8'h00); wr(0, 8'h07); wr(3, 8'h36);
    for (int k = 1; k <= 4; k++) do_tick(irq);
    check(irq == 1'b1, "R8 fire at zero", irq, 1);
    rd16(0, v); check(v == 16'h0006, "R8 odd reload made even", v, 6);
    // R3 alias 7 -> 3
    wr(3, 8'h3E); wr(0, 8'h04); wr(0, 8'h00);
    do_tick(irq); check(irq == 1'b0, "R3 mode 7 first tick", irq, 0);
    do_tick(irq); check(irq == 1'b1, "R3 mode 7 acts as 3", irq, 1);
    // R9 modes 1,4,5 hold
    for (int m = 0; m < 3; m++) begin
      logic [7:0] cw;
      cw = (m == 0) ? 8'h32 : (m == 1) ? 8'h38 : 8'h3A;
      wr(3, cw); wr(0, 8'h21); wr(0, 8'h00);
      for (int k = 0; k < 5; k++) begin
        do_tick(irq); check(irq == 1'b0, "R9 no fire", irq, 0);
      end
      rd16(0, v); check(v == 16'h0021, "R9 count held", v, 16'h21);
    end
    // R10 channel 1 does not drive irq0
    wr(3, 8'h74); wr(1, 8'h02); wr(1, 8'h00);
    for (int k = 1; k <= 6; k++) begin
      do_tick(irq); check(irq == 1'b0, "R10 channel 1 not routed", irq, 0);
    end
    rd16(1, v); check(v == 16'h0002, "R7 channel 1 reload", v, 2);
    // R10 no tick, no change
    repeat (10) @(negedge clk);
    rd16(1, v); check(v == 16'h0002, "R10 tick enable", v, 2);
    // R2 / R5 snapshot, access 3
    wr(3, 8'hB4); wr(2, 8'h34); wr(2, 8'h12);
    wr(3, 8'h80);
    for (int k = 0; k < 3; k++) do_tick(irq);
    rd16(2, v); check(v == 16'h1234, "R5 snapshot read", v, 16'h1234);
    rd16(2, v); check(v == 16'h1231, "R5 released after high byte", v, 16'h1231);
    // R5 access 1 release after one read
    wr(3, 8'h94); wr(2, 8'h50);
    rd(2, b); check(b == 8'h50, "R4 access 1 low byte", b, 8'h50);
    wr(3, 8'h80); do_tick(irq); do_tick(irq);
    rd(2, b); check(b == 8'h50, "R5 access 1 snapshot", b, 8'h50);
    rd(2, b); check(b == 8'h4E, "R5 access 1 released", b, 8'h4E);
    // R4 access 2 high byte
    wr(3, 8'hA4); wr(2, 8'h20);
    rd(2, b); check(b == 8'h20, "R4 access 2 high byte", b, 8'h20);
    wr(3, 8'hB4);
    rd16(2, v); check(v == 16'h2050, "R4 access 2 kept low byte", v, 16'h2050);
    // R3 control byte clears snapshot
    wr(3, 8'h80); do_tick(irq); wr(3, 8'hB4);
    rd16(2, v); check(v == 16'h204F, "R3 snapshot cleared", v, 16'h204F);
    done = 1'b1;
  end

  initial begin
    for (int n = 0; n < 150000 && !done; n++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule